// File: doc/BRIEF.md
# Sequence-Protected PWM Output Gate

This block sits between six PWM timer outputs and the pins that carry them. Two gate registers, one per channel group, each hold an output-kill bit. When a group's kill bit is set, that group's pins are forced low no matter what the PWM inputs do. Group A covers channels 0 to 2 and group B covers channels 3 to 5.

Setting a kill bit is guarded by an unlock pair. Software first writes the register with its arm bit high. The very next write to that register must have the arm bit low and the kill bit high. Between those two writes, no other master may write to any other address. If one does, the arm is lost and the commit write does nothing. Some bus masters, chosen by a parameter mask, are exempt: their writes elsewhere leave the arm in place. Clearing a kill bit takes only one ordinary write. Software is expected to mask interrupts and DMA while it runs the unlock pair.

The bus is a simple one-cycle register bus. A write is one clock with a write strobe, an address, data and a master ID. Read data is combinational and follows the address.

Top module: `pwm_out_guard`

## Requirements
- R1: After a synchronous active-low reset, both kill bits and both arm flags are 0, and every pin follows its PWM input.
- R2: A write to a group register with data bit 1 (arm) set makes that group armed. It leaves the kill bit unchanged, whatever data bit 0 holds.
- R3: When a group is armed, the next write to its register with bit 1 = 0 and bit 0 = 1 sets the kill bit and clears the arm flag. The change is visible one clock after the write.
- R4: A write with bit 1 = 0 and bit 0 = 1 to a group that is not armed is ignored, and the kill bit keeps its value.
- R5: A write from a non-exempt master to any other address clears the arm flag of an armed group, and a later commit write is then ignored. A write to the other group's register counts as another address.
- R6: A write to another address from an exempt master leaves the arm flag set. With the default parameters, master IDs 6 and 7 are exempt.
- R7: A write to an armed group's register with bit 1 = 0 and bit 0 = 0 drops the arm flag and also clears the kill bit.
- R8: A single write with bit 1 = 0 and bit 0 = 0 clears the kill bit, with no unlock needed.
- R9: While group A's kill bit is set, pins 0 to 2 are low. While group B's kill bit is set, pins 3 to 5 are low. A pin whose group is not killed equals its PWM input.
- R10: A read of a group register returns the kill bit in bit 0, the arm flag in bit 1 and zeros above. Any other address reads as 0. Reading, or presenting an address without the strobe, never changes the state.
- R11: The two groups are independent. No write to one group's register changes the other group's kill bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_mid | input | 3 | ID of the master driving the current access |
| bus_rdata | output | 8 | Read data for bus_addr |
| pwm_in | input | 6 | Raw PWM signals from the timers |
| pin_out | output | 6 | Gated signals to the pins |

## Verification
The assertions assume the bus gives exactly one address, one data word and one master ID per strobed cycle. They assume the master ID is valid whenever the strobe is high, and that reset is held for at least one clock edge. The bench drives every input at the falling edge and holds it for a whole cycle. It presents only the two register addresses plus one unrelated address, and it changes the master ID only together with a write. The PWM inputs are fixed patterns set while the bus is idle, so each pin check observes a settled combination of the kill bits and the inputs.

// File: rtl/pwm_guard_pkg.sv
// Package: shared constants for the PWM output gate.
// Assumes exactly two gate groups that split the channels evenly.
package pwm_guard_pkg;
    localparam int NUM_GRP  = 2;   // group A and group B
    localparam int KILL_BIT = 0;   // register bit holding the kill flag
    localparam int ARM_BIT  = 1;   // register bit holding the arm flag

    typedef struct packed {
        logic arm;
        logic kill;
    } grp_state_t;
endpackage

// File: rtl/pwm_grp_reg.sv
// Module: one gate register with its unlock sequencer.
// Does: holds the kill bit and the arm flag. The kill bit sets only on an
// arm-then-commit pair that no foreign write breaks.
// Assumes: wr_hit, wr_exempt and the data bits are valid while wr_stb is high.
module pwm_grp_reg
    import pwm_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       wr_hit,
    input  logic       wr_exempt,
    input  logic       wr_arm,
    input  logic       wr_kill,
    output grp_state_t state
);
    logic arm_q;
    logic kill_q;

    // Purpose: advance the unlock sequencer and the kill bit on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            kill_q <= 1'b0;
        end else if (wr_stb) begin
            if (wr_hit) begin
                if (wr_arm) begin
                    arm_q <= 1'b1;
                end else begin
                    arm_q <= 1'b0;
                    if (!wr_kill)
                        kill_q <= 1'b0;
                    else if (arm_q)
                        kill_q <= 1'b1;
                end
            end else if (!wr_exempt) begin
                arm_q <= 1'b0;
            end
        end
    end

    // Purpose: present the register state to the decode and gating logic.
    always_comb begin
        state.arm  = arm_q;
        state.kill = kill_q;
    end

    // R3: the kill bit rises only when the group was armed one cycle before
    p_commit_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kill_q) |-> $past(arm_q));
    // R4: a commit-shaped write to an unarmed group leaves the kill bit as it was
    p_unarmed_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_hit && !wr_arm && wr_kill && !arm_q) |=> $stable(kill_q));
    // R2: an arm write arms the group and does not move the kill bit
    p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_hit && wr_arm) |=> (arm_q && $stable(kill_q)));
    // R5: a foreign write from a non-exempt master drops the arm
    p_foreign_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_hit && !wr_exempt) |=> !arm_q);
    // R6: a foreign write from an exempt master keeps the arm
    p_exempt_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_hit && wr_exempt && arm_q) |=> arm_q);
    // R8: a clear write always leaves the kill bit low
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_hit && !wr_arm && !wr_kill) |=> (!kill_q && !arm_q));
    // R10: without a strobe the state does not move
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(kill_q) && $stable(arm_q)));
endmodule

// File: rtl/pwm_mid_filter.sv
// Module: master-ID exemption decoder.
// Does: flags a write whose master may not break an armed sequence.
// Assumes: EXEMPT_MASK has one bit per possible master ID.
module pwm_mid_filter #(
    parameter int MID_W = 3,
    parameter logic [(1<<MID_W)-1:0] EXEMPT_MASK = '0
) (
    input  logic [MID_W-1:0] mid,
    output logic             exempt
);
    // Purpose: look up the master ID in the exemption mask.
    always_comb exempt = EXEMPT_MASK[mid];
endmodule

// File: rtl/pwm_out_gate.sv
// Module: per-channel output gate.
// Does: forces each pin low while the kill bit of its group is set.
// Assumes: the channels divide evenly into groups, in ascending order.
module pwm_out_gate
    import pwm_guard_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0]  pwm_in,
    input  logic [NUM_GRP-1:0] grp_kill,
    output logic [NUM_CH-1:0]  pin_out
);
    localparam int CH_PER_GRP = NUM_CH / NUM_GRP;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = c / CH_PER_GRP;
        // Purpose: pass or block one channel according to its group's kill bit.
        always_comb pin_out[c] = pwm_in[c] & ~grp_kill[GRP];
    end
endmodule

// File: rtl/pwm_out_guard.sv
// Module: top of the sequence-protected PWM output gate.
// Does: decodes the register bus into two gate registers and gates six
// PWM outputs with their kill bits. Read data is combinational.
// Assumes: one write per strobed cycle, with a master ID valid alongside it.
module pwm_out_guard
    import pwm_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int MID_W  = 3,
    parameter int NUM_CH = 6,
    parameter logic [ADDR_W-1:0] ADDR_GRP_A = 8'h10,
    parameter logic [ADDR_W-1:0] ADDR_GRP_B = 8'h14,
    parameter logic [(1<<MID_W)-1:0] EXEMPT_MASK = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [MID_W-1:0]  bus_mid,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] pin_out
);
    localparam int CH_PER_GRP = NUM_CH / NUM_GRP;

    logic                 wr_exempt;
    logic [NUM_GRP-1:0]   grp_hit;
    logic [NUM_GRP-1:0]   grp_kill;
    grp_state_t           grp_st [NUM_GRP];

    pwm_mid_filter #(
        .MID_W       (MID_W),
        .EXEMPT_MASK (EXEMPT_MASK)
    ) i_mid_filter (
        .mid    (bus_mid),
        .exempt (wr_exempt)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] MY_ADDR = (g == 0) ? ADDR_GRP_A : ADDR_GRP_B;
        // Purpose: match the bus address against this group's register.
        always_comb grp_hit[g] = (bus_addr == MY_ADDR);

        pwm_grp_reg i_grp_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_stb    (bus_we),
            .wr_hit    (grp_hit[g]),
            .wr_exempt (wr_exempt),
            .wr_arm    (bus_wdata[ARM_BIT]),
            .wr_kill   (bus_wdata[KILL_BIT]),
            .state     (grp_st[g])
        );
        // Purpose: collect the kill bits for the output gate.
        always_comb grp_kill[g] = grp_st[g].kill;

        // R9: every pin of a killed group is low
        for (genvar k = 0; k < CH_PER_GRP; k++) begin : g_chk
            p_kill_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
                grp_kill[g] |-> !pin_out[g*CH_PER_GRP + k]);
        end
    end

    // Purpose: return the state of the addressed register, or zero otherwise.
    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp_hit[g]) begin
                bus_rdata[KILL_BIT] = grp_st[g].kill;
                bus_rdata[ARM_BIT]  = grp_st[g].arm;
            end
        end
    end

    pwm_out_gate #(
        .NUM_CH (NUM_CH)
    ) i_out_gate (
        .pwm_in   (pwm_in),
        .grp_kill (grp_kill),
        .pin_out  (pin_out)
    );

    // R11: a write to group B's register never moves group A's kill bit
    p_grp_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && grp_hit[1]) |=> $stable(grp_st[0].kill));
endmodule

// File: tb/test_pwm_out_guard.sv
module test_pwm_out_guard;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] A_ADDR = 8'h10;
    localparam logic [7:0] B_ADDR = 8'h14;
    localparam logic [7:0] X_ADDR = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_mid = '0;
    logic [7:0] bus_rdata;
    logic [5:0] pwm_in = '0;
    logic [5:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_out_guard i_pwm_out_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_mid   (bus_mid),
        .bus_rdata (bus_rdata),
        .pwm_in    (pwm_in),
        .pin_out   (pin_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobed write, launched at a falling edge; returns after the state has updated.
    task automatic wr(input logic [7:0] addr, input logic [7:0] data, input logic [2:0] mid);
        bus_addr  = addr;
        bus_wdata = data;
        bus_mid   = mid;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
        bus_mid   = '0;
    endtask

    task automatic rd(input logic [7:0] addr, output logic [7:0] data);
        bus_addr = addr;
        #1;
        data = bus_rdata;
    endtask

    task automatic pins(input string req, input logic [5:0] pat, input logic [5:0] exp);
        pwm_in = pat;
        #1;
        check(req, {2'b00, pin_out}, {2'b00, exp});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_ADDR, d); check("R1 A state", d, 8'h00);
        rd(B_ADDR, d); check("R1 B state", d, 8'h00);
        pins("R1 pins pattern1", 6'b101101, 6'b101101);
        pins("R1 pins pattern2", 6'b010010, 6'b010010);
    endtask

    task automatic t_valid_pair();
        logic [7:0] d;
        wr(A_ADDR, 8'h02, 3'd0);
        rd(A_ADDR, d); check("R2 armed after arm write", d, 8'h02);
        wr(A_ADDR, 8'h01, 3'd0);
        rd(A_ADDR, d); check("R3 commit sets kill", d, 8'h01);
        pins("R9 group A low", 6'h3F, 6'b111000);
        pins("R9 group B follows", 6'b010101, 6'b010000);
        rd(B_ADDR, d); check("R11 B untouched", d, 8'h00);
        wr(B_ADDR, 8'h00, 3'd0);
        rd(A_ADDR, d); check("R11 A kill kept after B write", d, 8'h01);
        wr(A_ADDR, 8'h00, 3'd0);
        rd(A_ADDR, d); check("R8 single clear", d, 8'h00);
        pins("R8 pins restored", 6'h3F, 6'h3F);
    endtask

    task automatic t_unarmed();
        logic [7:0] d;
        wr(A_ADDR, 8'h01, 3'd0);
        rd(A_ADDR, d); check("R4 commit without arm ignored", d, 8'h00);
        wr(A_ADDR, 8'h03, 3'd0);
        rd(A_ADDR, d); check("R2 arm with kill bit keeps kill", d, 8'h02);
        wr(A_ADDR, 8'h00, 3'd0);
    endtask

    task automatic t_broken();
        logic [7:0] d;
        wr(A_ADDR, 8'h02, 3'd0);
        wr(X_ADDR, 8'h55, 3'd1);
        rd(A_ADDR, d); check("R5 foreign write drops arm", d, 8'h00);
        wr(A_ADDR, 8'h01, 3'd0);
        rd(A_ADDR, d); check("R5 commit after break ignored", d, 8'h00);
        pins("R5 pins still driven", 6'h3F, 6'h3F);
        wr(A_ADDR, 8'h02, 3'd0);
        wr(B_ADDR, 8'h00, 3'd5);
        wr(A_ADDR, 8'h01, 3'd0);
        rd(A_ADDR, d); check("R5 other group write breaks pair", d, 8'h00);
    endtask

    task automatic t_exempt();
        logic [7:0] d;
        wr(B_ADDR, 8'h02, 3'd0);
        wr(X_ADDR, 8'hAA, 3'd6);
        rd(B_ADDR, d); check("R6 id6 keeps arm", d, 8'h02);
        wr(X_ADDR, 8'h11, 3'd7);
        rd(B_ADDR, d); check("R6 id7 keeps arm", d, 8'h02);
        wr(B_ADDR, 8'h01, 3'd0);
        rd(B_ADDR, d); check("R6 commit after exempt writes", d, 8'h01);
        pins("R9 group B low", 6'h3F, 6'b000111);
        rd(A_ADDR, d); check("R11 A untouched by B", d, 8'h00);
        wr(B_ADDR, 8'h00, 3'd0);
        rd(B_ADDR, d); check("R8 clear B", d, 8'h00);
    endtask

    task automatic t_bad_next();
        logic [7:0] d;
        wr(A_ADDR, 8'h02, 3'd0);
        wr(A_ADDR, 8'h01, 3'd0);
        wr(A_ADDR, 8'h02, 3'd0);
        rd(A_ADDR, d); check("R2 re-arm keeps kill", d, 8'h03);
        wr(A_ADDR, 8'h00, 3'd0);
        rd(A_ADDR, d); check("R7 clear write drops arm and kill", d, 8'h00);
        wr(A_ADDR, 8'h01, 3'd0);
        rd(A_ADDR, d); check("R7 later commit ignored", d, 8'h00);
    endtask

    task automatic t_read_keep();
        logic [7:0] d;
        wr(A_ADDR, 8'h02, 3'd0);
        bus_addr = B_ADDR; @(negedge clk);
        bus_addr = X_ADDR; bus_mid = 3'd2; @(negedge clk);
        bus_mid = 3'd0;
        rd(X_ADDR, d); check("R10 unmapped reads zero", d, 8'h00);
        rd(A_ADDR, d); check("R10 reads keep arm", d, 8'h02);
        wr(A_ADDR, 8'h01, 3'd0);
        rd(A_ADDR, d); check("R10 commit after reads", d, 8'h01);
        wr(A_ADDR, 8'h00, 3'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_valid_pair();
        t_unarmed();
        t_broken();
        t_exempt();
        t_bad_next();
        t_read_keep();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule